// File: doc/BRIEF.md
# Serial Display Configuration Streamer

This block turns a stream of 8-bit configuration words into transfers on a four-wire serial display link. Each word arrives with a flag that says whether it is a command or a parameter byte. An accepted word is loaded into a holding shift register. It is then sent most significant bit first. While it is sent, chip select is low and the data/command line reflects the flag. The serial clock is a divided copy of the system clock.

Some commands need the display to settle before anything else reaches it: the soft-reset command (0x01) and the leave-sleep command (0x11). After either one finishes, the block keeps its input stalled for a programmable number of system cycles. Other command codes, including the no-operation code 0x00, cause no stall. Parameter bytes never cause a stall. The block also drives an active-low display reset pin. That pin is held low while the block is in reset, and no transfer starts while it is low.

Top module: `lcd_cmd_streamer`

## Requirements
- R1: While rstN is low, lcdCsN is 1, lcdSclk is 0, lcdRstN is 0 and sTready is 0. In the first cycle after rstN is released, lcdRstN rises and sTready rises with it.
- R2: A word is accepted on a clock edge where sTvalid and sTready are both 1. sTready is 0 in the following cycle and stays 0 for as long as lcdCsN is low.
- R3: Each accepted word produces exactly 8 rising edges of lcdSclk while lcdCsN is low. The display sees sTdata[7] first and sTdata[0] last.
- R4: The link runs in SPI mode 0. lcdSclk is low whenever lcdCsN is high, and lcdMosi changes only while lcdSclk is low.
- R5: lcdDcx is 0 for a command word (sTisData = 0) and 1 for a parameter word (sTisData = 1). It is valid from the cycle in which lcdCsN falls and is stable until lcdCsN rises.
- R6: Each bit lasts CLK_DIV system cycles, half with lcdSclk low and half with it high. lcdCsN stays low for exactly 8*CLK_DIV cycles per word.
- R7: After a command word of value 0x01, sTready stays 0 for RESET_WAIT cycles after the cycle in which lcdCsN rises.
- R8: After a command word of value 0x11, sTready stays 0 for SLEEP_WAIT cycles after the cycle in which lcdCsN rises.
- R9: After any other command word (including 0x00), and after any parameter word (including the values 0x01 and 0x11), sTready returns to 1 in the same cycle in which lcdCsN rises.
- R10: Every accepted word yields exactly one lcdCsN low period. No word is dropped or sent twice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| sTvalid | input | 1 | Stream word valid |
| sTready | output | 1 | Stream word can be accepted |
| sTdata | input | 8 | Stream word payload |
| sTisData | input | 1 | 1 = parameter byte, 0 = command byte |
| lcdCsN | output | 1 | Active-low chip select |
| lcdSclk | output | 1 | Serial clock, idle low |
| lcdMosi | output | 1 | Serial data to the display |
| lcdDcx | output | 1 | Data/command select, low for command |
| lcdRstN | output | 1 | Active-low display reset |

## Verification
The assertions assume that sTvalid, sTdata and sTisData are known at every clock edge, and that rstN changes away from the active clock edge. The bench meets both by driving every input on the falling system clock edge. It raises sTvalid only after reset, and it drops sTvalid the cycle after a handshake. The protocol properties (idle clock level, data stability while the serial clock is high, data/command stability over a frame) hold regardless of input timing. The handshake properties rely on valid being sampled cleanly, so the bench never toggles it near a rising edge.

// File: rtl/lcd_stream_pkg.sv
package lcd_stream_pkg;

  localparam int WORD_W = 8;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic load;   // capture word, drop chip select
    logic rise;   // drive serial clock high
    logic shift;  // drive serial clock low and present next bit
    logic done;   // drive serial clock low and release chip select
  } strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_HOLD  = 2'd2
  } state_t;

  typedef enum logic [1:0] {
    WK_NONE  = 2'd0,
    WK_RESET = 2'd1,
    WK_SLEEP = 2'd2
  } waitKind_t;

endpackage

// File: rtl/lcd_stream_ctrl.sv
module lcd_stream_ctrl
  import lcd_stream_pkg::*;
#(
  parameter int CLK_DIV     = 6,
  parameter int RESET_WAIT  = 250000,
  parameter int SLEEP_WAIT  = 6000000,
  parameter logic [WORD_W-1:0] RESET_CODE = 8'h01,
  parameter logic [WORD_W-1:0] SLEEP_CODE = 8'h11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              linkUp,
  input  logic              sTvalid,
  input  logic              sTisData,
  input  logic [WORD_W-1:0] sTdata,
  output logic              sTready,
  output strobe_t           strobe
);

  localparam int HALF    = CLK_DIV / 2;
  localparam int DIV_W   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BIT_W   = $clog2(WORD_W);
  localparam int MAX_WT  = (RESET_WAIT > SLEEP_WAIT) ? RESET_WAIT : SLEEP_WAIT;
  localparam int WAIT_W  = $clog2(MAX_WT + 1);
  localparam logic [BIT_W-1:0]  LAST_BIT   = BIT_W'(WORD_W - 1);
  localparam logic [WAIT_W-1:0] RESET_LOAD = WAIT_W'(RESET_WAIT - 1);
  localparam logic [WAIT_W-1:0] SLEEP_LOAD = WAIT_W'(SLEEP_WAIT - 1);

  state_t            state;
  waitKind_t         pendKind;
  logic [BIT_W-1:0]  bitCnt;
  logic [WAIT_W-1:0] waitCnt;
  logic              phaseHigh;
  logic              halfDone;
  logic              accept;
  waitKind_t         decodedKind;

  // Half-period timer: a divide-by-2 needs no counter at all
  generate
    if (HALF > 1) begin : g_divCnt
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          divCnt <= '0;
        end else if (state != ST_SHIFT || halfDone) begin
          divCnt <= '0;
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
      assign halfDone = (state == ST_SHIFT) && (divCnt == DIV_W'(HALF - 1));
    end else begin : g_noDiv
      assign halfDone = (state == ST_SHIFT);
    end
  endgenerate

  always_comb begin
    decodedKind = WK_NONE;
    if (!sTisData) begin
      if (sTdata == RESET_CODE)      decodedKind = WK_RESET;
      else if (sTdata == SLEEP_CODE) decodedKind = WK_SLEEP;
    end
  end

  assign sTready = (state == ST_IDLE) && linkUp;
  assign accept  = sTvalid && sTready;

  always_comb begin
    strobe      = '0;
    strobe.load = accept;
    if (halfDone) begin
      if (!phaseHigh)               strobe.rise  = 1'b1;
      else if (bitCnt == LAST_BIT)  strobe.done  = 1'b1;
      else                          strobe.shift = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      pendKind  <= WK_NONE;
      bitCnt    <= '0;
      waitCnt   <= '0;
      phaseHigh <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state     <= ST_SHIFT;
            pendKind  <= decodedKind;
            bitCnt    <= '0;
            phaseHigh <= 1'b0;
          end
        end
        ST_SHIFT: begin
          if (halfDone) begin
            phaseHigh <= ~phaseHigh;
            if (phaseHigh) begin
              bitCnt <= bitCnt + 1'b1;
              if (bitCnt == LAST_BIT) begin
                case (pendKind)
                  WK_RESET: begin state <= ST_HOLD; waitCnt <= RESET_LOAD; end
                  WK_SLEEP: begin state <= ST_HOLD; waitCnt <= SLEEP_LOAD; end
                  default:  state <= ST_IDLE;
                endcase
              end
            end
          end
        end
        ST_HOLD: begin
          if (waitCnt == '0) state <= ST_IDLE;
          else               waitCnt <= waitCnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lcd_stream_dp.sv
module lcd_stream_dp
  import lcd_stream_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [WORD_W-1:0] sTdata,
  input  logic              sTisData,
  output logic              linkUp,
  output logic              lcdCsN,
  output logic              lcdSclk,
  output logic              lcdMosi,
  output logic              lcdDcx,
  output logic              lcdRstN
);

  logic [WORD_W-1:0] shiftReg;

  // Display reset follows block reset, released one cycle later
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lcdRstN <= 1'b0;
    else       lcdRstN <= 1'b1;
  end
  assign linkUp = lcdRstN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      lcdCsN   <= 1'b1;
      lcdSclk  <= 1'b0;
      lcdMosi  <= 1'b0;
      lcdDcx   <= 1'b0;
    end else begin
      if (strobe.load) begin
        shiftReg <= sTdata;
        lcdMosi  <= sTdata[WORD_W-1];
        lcdDcx   <= sTisData;
        lcdCsN   <= 1'b0;
        lcdSclk  <= 1'b0;
      end
      if (strobe.rise) lcdSclk <= 1'b1;
      if (strobe.shift) begin
        lcdSclk  <= 1'b0;
        shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
        lcdMosi  <= shiftReg[WORD_W-2];
      end
      if (strobe.done) begin
        lcdSclk <= 1'b0;
        lcdCsN  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/lcd_cmd_streamer.sv
module lcd_cmd_streamer
  import lcd_stream_pkg::*;
#(
  parameter int CLK_DIV    = 6,
  parameter int RESET_WAIT = 250000,
  parameter int SLEEP_WAIT = 6000000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sTvalid,
  output logic       sTready,
  input  logic [7:0] sTdata,
  input  logic       sTisData,
  output logic       lcdCsN,
  output logic       lcdSclk,
  output logic       lcdMosi,
  output logic       lcdDcx,
  output logic       lcdRstN
);

  strobe_t strobe;
  logic    linkUp;

  lcd_stream_ctrl #(
    .CLK_DIV    (CLK_DIV),
    .RESET_WAIT (RESET_WAIT),
    .SLEEP_WAIT (SLEEP_WAIT)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .linkUp   (linkUp),
    .sTvalid  (sTvalid),
    .sTisData (sTisData),
    .sTdata   (sTdata),
    .sTready  (sTready),
    .strobe   (strobe)
  );

  lcd_stream_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .sTdata   (sTdata),
    .sTisData (sTisData),
    .linkUp   (linkUp),
    .lcdCsN   (lcdCsN),
    .lcdSclk  (lcdSclk),
    .lcdMosi  (lcdMosi),
    .lcdDcx   (lcdDcx),
    .lcdRstN  (lcdRstN)
  );

endmodule

// File: rtl/lcd_stream_checker.sv
module lcd_stream_checker (
  input logic       clk,
  input logic       rstN,
  input logic       sTvalid,
  input logic       sTready,
  input logic       lcdCsN,
  input logic       lcdSclk,
  input logic       lcdMosi,
  input logic       lcdDcx,
  input logic       lcdRstN
);

  AST_RST_HOLDS_PANEL: assert property (@(posedge clk) !rstN |=> !lcdRstN); // R1

  AST_READY_LOW_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    !lcdCsN |-> !sTready); // R2

  AST_ACCEPT_OPENS_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    (sTvalid && sTready) |=> (!lcdCsN && !sTready)); // R2

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    lcdCsN |-> !lcdSclk); // R4

  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (lcdSclk && $past(lcdSclk)) |-> $stable(lcdMosi)); // R4

  AST_DCX_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!lcdCsN && !$past(lcdCsN)) |-> $stable(lcdDcx)); // R5

endmodule

bind lcd_cmd_streamer lcd_stream_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .sTvalid (sTvalid),
  .sTready (sTready),
  .lcdCsN  (lcdCsN),
  .lcdSclk (lcdSclk),
  .lcdMosi (lcdMosi),
  .lcdDcx  (lcdDcx),
  .lcdRstN (lcdRstN)
);

// File: tb/lcd_cmd_streamer_bench.sv
`timescale 1ns/1ps
module lcd_cmd_streamer_bench;

  localparam int CLK_DIV = 4;
  localparam int RW      = 40;
  localparam int SW      = 100;
  localparam int NVEC    = 10;

  // {isData, data[7:0], expected wait[15:0]}
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b0, 8'h00, 16'd0},   // R9 no-op command
    {1'b0, 8'h01, 16'(RW)}, // R7 soft reset
    {1'b1, 8'h01, 16'd0},   // R9 parameter with reset value
    {1'b0, 8'h11, 16'(SW)}, // R8 leave sleep
    {1'b1, 8'h11, 16'd0},   // R9 parameter with sleep value
    {1'b0, 8'h36, 16'd0},
    {1'b1, 8'hA5, 16'd0},
    {1'b1, 8'h5A, 16'd0},
    {1'b0, 8'h29, 16'd0},
    {1'b0, 8'h10, 16'd0}    // R9 enter-sleep is not a wait code
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sTvalid = 1'b0;
  logic       sTready;
  logic [7:0] sTdata = 8'h00;
  logic       sTisData = 1'b0;
  logic       lcdCsN, lcdSclk, lcdMosi, lcdDcx, lcdRstN;

  int errors = 0;
  int checks = 0;
  int sent = 0;
  int framesSeen = 0;
  int sclkRises = 0;
  logic [7:0] rxByte = 8'h00;
  logic [7:0] rxDc = 8'h00;

  always #2.5 clk = ~clk;

  lcd_cmd_streamer #(
    .CLK_DIV(CLK_DIV), .RESET_WAIT(RW), .SLEEP_WAIT(SW)
  ) u_lcd_cmd_streamer (
    .clk(clk), .rstN(rstN), .sTvalid(sTvalid), .sTready(sTready),
    .sTdata(sTdata), .sTisData(sTisData), .lcdCsN(lcdCsN),
    .lcdSclk(lcdSclk), .lcdMosi(lcdMosi), .lcdDcx(lcdDcx), .lcdRstN(lcdRstN)
  );

  always @(posedge lcdSclk) begin
    rxByte    <= {rxByte[6:0], lcdMosi};
    rxDc      <= {rxDc[6:0], lcdDcx};
    sclkRises <= sclkRises + 1;
  end

  always @(negedge lcdCsN) framesSeen <= framesSeen + 1;

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic sendWord(input logic isData, input logic [7:0] data, input int expWait);
    int riseStart;
    int csLow;
    int waitCyc;
    @(negedge clk);
    sTvalid = 1'b1; sTdata = data; sTisData = isData;
    while (!sTready) @(negedge clk);
    riseStart = sclkRises;
    @(negedge clk);
    sTvalid = 1'b0;
    sent++;
    check("R2 ready low after accept", int'(sTready), 0);
    csLow = 0;
    while (!lcdCsN) begin csLow++; @(negedge clk); end
    check("R6 chip select low cycles", csLow, 8 * CLK_DIV);
    check("R3 eight clock rises", sclkRises - riseStart, 8);
    check("R3 byte MSB first", int'(rxByte), int'(data));
    check("R5 data/command level", int'(rxDc), isData ? 255 : 0);
    waitCyc = 0;
    while (!sTready) begin waitCyc++; @(negedge clk); end
    check("R7/R8/R9 stall after frame", waitCyc, expWait);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 csN in reset", int'(lcdCsN), 1);
    check("R1 sclk in reset", int'(lcdSclk), 0);
    check("R1 panel reset low", int'(lcdRstN), 0);
    check("R1 ready low in reset", int'(sTready), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 panel reset released", int'(lcdRstN), 1);
    check("R1 ready after reset", int'(sTready), 1);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      sendWord(VEC[i][24], VEC[i][23:16], int'(VEC[i][15:0]));
    end

    // R10 one frame per accepted word
    check("R10 frames equal words", framesSeen, sent);

    // R1 reset during a frame
    @(negedge clk);
    sTvalid = 1'b1; sTdata = 8'hC3; sTisData = 1'b1;
    while (!sTready) @(negedge clk);
    @(negedge clk);
    sTvalid = 1'b0;
    sent++;
    repeat (5) @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R1 csN forced high", int'(lcdCsN), 1);
    check("R1 sclk forced low", int'(lcdSclk), 0);
    check("R1 panel reset asserted", int'(lcdRstN), 0);
    check("R1 ready dropped", int'(sTready), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 ready back after reset", int'(sTready), 1);

    // Back-to-back after reset: sleep exit then command
    sendWord(1'b0, 8'h11, SW);
    sendWord(1'b0, 8'h01, RW);
    sendWord(1'b1, 8'h80, 0);
    check("R10 frames equal words after reset", framesSeen, sent);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule